// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps time as an unsigned 32-bit count of elapsed seconds. A prescaler divides the block clock (nominally 32768 Hz) down to a one-cycle seconds tick, and each tick advances the count while the run bit is set. The count wraps from its all-ones value to zero. Software reaches the block through a byte-wide, byte-addressed register port with one-cycle writes and combinational reads.

A new time is loaded in stages. The three upper bytes are written into holding registers. Writing the low byte then commits all four bytes to the counter in a single clock and restarts the prescaler. Software first writes zero to the low byte so that no carry can ripple into the upper bytes while they are being rewritten. Reads of the count are live and have no snapshot. Software must therefore reread the low byte to detect a carry that occurred between its byte reads.

A 32-bit alarm value is compared with the count at every seconds tick. When the alarm is armed and the tick brings the count to the alarm value, a pending flag is set. That flag drives the interrupt output as a level whose rising edge marks the alarm. The flag stays set until software writes the acknowledge bit.

Top module: `seconds_rtc`

## Requirements
- R1: After reset, every register reads 0x00 and `alarm_irq_o` is low.
- R2: The count advances by one on each seconds tick, and a tick occurs once every `DIV` clocks. While bit 7 of the control register (offset 0x00) is clear, neither the count nor the prescaler moves.
- R3: Writes to offsets 0x03, 0x04 and 0x05 hold count bytes 1, 2 and 3 and leave the count unchanged. A write to offset 0x02 loads the count with {byte3, byte2, byte1, written value} in one clock. It also restarts the prescaler, so the next tick comes `DIV` clocks after the load.
- R4: Offsets 0x06 to 0x09 return count bytes 0 to 3 (least significant at 0x06). They reflect the live count, with no latching between reads.
- R5: A tick at count 0xFFFFFFFF yields count 0x00000000.
- R6: Bit 7 of offset 0x00 (run) and bit 7 of offset 0x01 (alarm enable) read back as written, and all other bits of those registers read 0. The alarm value is read/write at offsets 0x0A to 0x0D, least significant byte first.
- R7: `alarm_irq_o` rises at the clock edge on which a tick moves the count to the alarm value, provided run and alarm enable are both set.
- R8: With alarm enable clear, no tick sets the alarm.
- R9: Once set, `alarm_irq_o` stays high across further ticks until a write to offset 0x0E has bit 0 set. A write there with bit 0 clear has no effect.
- R10: Offsets 0x02 to 0x05, 0x0E and every address at or above 0x0F read 0x00. Writes to addresses at or above 0x0F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the prescaler input |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one byte per cycle |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| alarm_irq_o | output | 1 | Alarm pending level, rising edge signals the alarm |

## Verification
The bench aims at the prescaler restart on a low-byte load. A design that forgot it would tick early, and the count would be one ahead at the first read after the load. Staged upper-byte writes are checked against the count and must leave it alone; a design that wrote them through would show the new upper byte before the commit. Wrap-around at all-ones is checked, and so is the arrival of the alarm at exactly the matching tick. The pending flag must survive both later ticks and an acknowledge write whose bit 0 is zero; a design that tested the wrong bit or cleared on any write would drop the interrupt early. Holes in the map and write-only locations must read zero and must not alias onto the alarm or control registers.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned TIME_W     = 32;
  localparam int unsigned TIME_BYTES = TIME_W / BYTE_W;

  localparam int unsigned OFF_CTRL   = 'h00;
  localparam int unsigned OFF_ACTRL  = 'h01;
  localparam int unsigned OFF_WDATA  = 'h02;
  localparam int unsigned OFF_RDATA  = 'h06;
  localparam int unsigned OFF_ALARM  = 'h0A;
  localparam int unsigned OFF_ACLR   = 'h0E;

  localparam int unsigned BIT_RUN    = 7;
  localparam int unsigned BIT_AEN    = 7;
  localparam int unsigned BIT_ACK    = 0;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1; // natural wrap
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         armed_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] alarm_val_i,
  input  logic         ack_i,
  output logic         pending_o
);
  logic [W-1:0] next_cnt;
  logic         hit;
  logic         pend_q;

  // compare against the value the tick is about to produce
  assign next_cnt = count_i + 1'b1;
  assign hit      = tick_i && armed_i && (next_cnt == alarm_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (hit)   pend_q <= 1'b1; // a fresh hit beats a same-cycle ack
    else if (ack_i) pend_q <= 1'b0;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [TIME_W-1:0] count_i,
  output logic              run_o,
  output logic              alarm_en_o,
  output logic [TIME_W-1:0] alarm_val_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned NB = TIME_BYTES;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic run_q, aen_q;
  logic [BYTE_W-1:0] stage_q [1:NB-1];
  logic [BYTE_W-1:0] alarm_q [0:NB-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      aen_q <= 1'b0;
    end else if (wr_en_i) begin
      if (hit_addr(addr_i, OFF_CTRL))  run_q <= wdata_i[BIT_RUN];
      if (hit_addr(addr_i, OFF_ACTRL)) aen_q <= wdata_i[BIT_AEN];
    end
  end

  for (genvar b = 1; b < NB; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[b] <= '0;
      else if (wr_en_i && hit_addr(addr_i, OFF_WDATA + b)) stage_q[b] <= wdata_i;
    end
    assign load_val_o[b*BYTE_W +: BYTE_W] = stage_q[b];
  end

  for (genvar b = 0; b < NB; b++) begin : g_alarm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alarm_q[b] <= '0;
      else if (wr_en_i && hit_addr(addr_i, OFF_ALARM + b)) alarm_q[b] <= wdata_i;
    end
    assign alarm_val_o[b*BYTE_W +: BYTE_W] = alarm_q[b];
  end

  assign load_val_o[BYTE_W-1:0] = wdata_i;
  assign load_o     = wr_en_i && hit_addr(addr_i, OFF_WDATA);
  assign ack_o      = wr_en_i && hit_addr(addr_i, OFF_ACLR) && wdata_i[BIT_ACK];
  assign run_o      = run_q;
  assign alarm_en_o = aen_q;

  always_comb begin
    rdata_o = '0;
    if (hit_addr(addr_i, OFF_CTRL))  rdata_o[BIT_RUN] = run_q;
    if (hit_addr(addr_i, OFF_ACTRL)) rdata_o[BIT_AEN] = aen_q;
    for (int b = 0; b < NB; b++) begin
      if (hit_addr(addr_i, OFF_RDATA + b)) rdata_o = count_i[b*BYTE_W +: BYTE_W];
      if (hit_addr(addr_i, OFF_ALARM + b)) rdata_o = alarm_q[b];
    end
  end
endmodule

// File: rtl/seconds_rtc.sv
module seconds_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV    = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_irq_o
);
  logic              run_en, alarm_en, load, ack, tick;
  logic [TIME_W-1:0] count_q, load_val, alarm_val;

  rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .count_i    (count_q),
    .run_o      (run_en),
    .alarm_en_o (alarm_en),
    .alarm_val_o(alarm_val),
    .load_o     (load),
    .load_val_o (load_val),
    .ack_o      (ack),
    .rdata_o    (rdata_o)
  );

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_en),
    .restart_i(load),
    .tick_o   (tick)
  );

  rtc_counter #(.W(TIME_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (tick),
    .count_o   (count_q)
  );

  rtc_alarm #(.W(TIME_W)) u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .armed_i    (run_en && alarm_en),
    .count_i    (count_q),
    .alarm_val_i(alarm_val),
    .ack_i      (ack),
    .pending_o  (alarm_irq_o)
  );
endmodule

// File: rtl/seconds_rtc_chk.sv
module seconds_rtc_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              alarm_irq_o,
  input logic              run_en,
  input logic              alarm_en,
  input logic              tick,
  input logic [31:0]       count_q,
  input logic [31:0]       alarm_val
);
  logic ld_w, ack_w;
  assign ld_w  = wr_en_i && (addr_i == ADDR_W'(2));
  assign ack_w = wr_en_i && (addr_i == ADDR_W'(14)) && wdata_i[0];

  a_r2_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !ld_w) |=> $stable(count_q));

  a_r2_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_w) |=> (count_q == $past(count_q) + 32'd1));

  a_r3_low_byte_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_w |=> (count_q[7:0] == $past(wdata_i)));

  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_w && count_q == 32'hFFFF_FFFF) |=> (count_q == 32'd0));

  a_r7_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_irq_o) |-> (count_q == $past(alarm_val)));

  a_r8_quiet_when_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_en && !alarm_irq_o) |=> !alarm_irq_o);

  a_r9_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_irq_o && !ack_w) |=> alarm_irq_o);
endmodule

bind seconds_rtc seconds_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .alarm_irq_o(alarm_irq_o),
  .run_en     (run_en),
  .alarm_en   (alarm_en),
  .tick       (tick),
  .count_q    (count_q),
  .alarm_val  (alarm_val)
);

// File: tb/seconds_rtc_tb.sv
`timescale 1ns/100ps
module seconds_rtc_tb;
  localparam int AW  = 5;
  localparam int DIV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wd = '0;
  logic [7:0]    rdata;
  logic          irq;

  int    n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk; // 250 MHz

  seconds_rtc #(.ADDR_W(AW), .DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .alarm_irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_cnt, m_alm;
  logic [7:0]  m_st [1:3];
  logic        m_run, m_aen, m_pend;
  int          m_pre;

  function automatic logic [7:0] m_read(input int a);
    if (a == 0) return {m_run, 7'd0};
    if (a == 1) return {m_aen, 7'd0};
    if (a >= 6 && a <= 9)   return 8'(m_cnt >> (8 * (a - 6)));
    if (a >= 10 && a <= 13) return 8'(m_alm >> (8 * (a - 10)));
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = 0; m_run = 0; m_aen = 0; m_pend = 0; m_pre = 0;
      for (int i = 1; i <= 3; i++) m_st[i] = 0;
    end else begin
      bit tk, ld, hit;
      int a;
      a  = int'(addr);
      ld = we && a == 2;
      tk = 0;
      if (ld) m_pre = 0;
      else if (m_run) begin
        if (m_pre == DIV - 1) begin m_pre = 0; tk = 1; end
        else m_pre++;
      end
      hit = tk && m_run && m_aen && (m_cnt + 32'd1 == m_alm);
      if (ld) m_cnt = {m_st[3], m_st[2], m_st[1], wd};
      else if (tk) m_cnt = m_cnt + 32'd1;
      if (hit) m_pend = 1;
      else if (we && a == 14 && wd[0]) m_pend = 0;
      if (we) begin
        if (a == 0) m_run = wd[7];
        if (a == 1) m_aen = wd[7];
        if (a >= 3 && a <= 5) m_st[a-2] = wd;
        if (a >= 10 && a <= 13) m_alm[8*(a-10) +: 8] = wd;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      n_tests++;
      if (irq !== m_pend || rdata !== m_read(int'(addr))) begin
        n_fail++;
        $display("FAIL %s model: irq=%0b rdata=%02h expected irq=%0b rdata=%02h",
                 cur_req, irq, rdata, m_pend, m_read(int'(addr)));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = AW'(a); wd = d;
    @(negedge clk); we = 0; wd = 0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
    @(negedge clk); we = 0; addr = AW'(a);
    #1.5;
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s rd[%02h]: actual=%02h expected=%02h", req, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string req);
    @(negedge clk); #1.5;
    n_tests++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq: actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    cur_req = "R1";
    for (int a = 0; a < 32; a++) rd_chk(a, 8'h00, "R1");
    irq_chk(1'b0, "R1");

    cur_req = "R6";
    wr(0, 8'hFF); rd_chk(0, 8'h80, "R6");
    wr(1, 8'hFF); rd_chk(1, 8'h80, "R6");
    wr(1, 8'h00);
    wr(10, 8'hA1); wr(13, 8'h5C);
    rd_chk(10, 8'hA1, "R6"); rd_chk(13, 8'h5C, "R6");

    cur_req = "R3";
    wr(0, 8'h00);
    wr(2, 8'h00);
    wr(3, 8'h56); wr(4, 8'h34); wr(5, 8'h12);
    rd_chk(9, 8'h00, "R3"); rd_chk(7, 8'h00, "R3");
    wr(2, 8'h78);
    rd_chk(6, 8'h78, "R4"); rd_chk(7, 8'h56, "R4");
    rd_chk(8, 8'h34, "R4"); rd_chk(9, 8'h12, "R4");

    cur_req = "R2";
    idle(20);
    rd_chk(6, 8'h78, "R2");

    wr(0, 8'h80);
    wr(2, 8'h10);
    idle(6);
    rd_chk(6, 8'h10, "R3");
    rd_chk(6, 8'h11, "R4");
    rd_chk(9, 8'h12, "R2");

    cur_req = "R5";
    wr(0, 8'h00);
    wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF); wr(2, 8'hFF);
    rd_chk(6, 8'hFF, "R5"); rd_chk(9, 8'hFF, "R5");
    wr(0, 8'h80);
    idle(10);
    for (int a = 6; a <= 9; a++) rd_chk(a, 8'h00, "R5");

    cur_req = "R7";
    wr(0, 8'h00);
    wr(10, 8'h05); wr(11, 8'h00); wr(12, 8'h00); wr(13, 8'h00);
    wr(1, 8'h80);
    wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00); wr(2, 8'h03);
    irq_chk(1'b0, "R7");
    wr(0, 8'h80);
    idle(30);
    irq_chk(1'b1, "R7");

    cur_req = "R9";
    idle(20);
    irq_chk(1'b1, "R9");
    wr(14, 8'hFE);
    irq_chk(1'b1, "R9");
    wr(14, 8'h01);
    irq_chk(1'b0, "R9");

    cur_req = "R8";
    wr(1, 8'h00);
    wr(2, 8'h03);
    idle(30);
    irq_chk(1'b0, "R8");

    cur_req = "R10";
    wr(15, 8'hFF); wr(31, 8'hFF); wr(16, 8'h80);
    rd_chk(15, 8'h00, "R10"); rd_chk(31, 8'h00, "R10");
    rd_chk(14, 8'h00, "R10"); rd_chk(3, 8'h00, "R10");
    rd_chk(2, 8'h00, "R10");
    rd_chk(1, 8'h00, "R10"); rd_chk(0, 8'h80, "R10");
    rd_chk(10, 8'h05, "R10"); rd_chk(13, 8'h00, "R10");

    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule